// File: doc/BRIEF.md
# Video Decoder Capture Front-End

This block sits behind the pins of an external video decoder that sends pixels on a synchronous bus. The bus is clocked by the decoder's own video clock. Each clock carries a 16-bit pixel word plus four control lines:

- a vertical pulse that opens a new field;
- a field-identification line that gives the field's parity;
- a line-active qualifier that frames the pixels of one line;
- an optional alpha-key bit.

Each control line passes through its own polarity bit first. The block then finds the field and line boundaries and keeps only the words that arrive while the qualifier is active. It tags every kept word with the field parity, start-of-field, start-of-line and end-of-line flags, and a linear write address. The result is one write beat per clock, ready for a memory writer downstream.

The address is a base plus the line index times a line pitch plus the pixel index. The base is taken at each field start. The pitch is programmable. An upstream scaler may leave whole lines with no qualifier. Those lines produce no writes and do not consume a line slot in the address space. At every field start, two status outputs report how many words and how many active lines the previous field delivered.

Top module: `vcapFront`

## Requirements
- R1: All inputs are sampled on the rising clock edge. Each control line is XORed with its polarity bit before any edge detection, so a polarity bit of 1 makes that line active-low: `polVref` for `vrefIn`, `polField` for `fieldIn`, `polVact` for `vactIn`, `polAlpha` for `alphaIn`.
- R2: A field start happens once, at the trailing edge of the vertical pulse, however many lines the pulse lasts (2 to 9). The first beat after a field start has `wrSof`=1 and every other beat has `wrSof`=0.
- R3: The field parity is the field-identification value sampled in the last clock in which the pulse was still active. `wrField` carries that parity on every beat until the next field start. Changes of the field input after the trailing edge have no effect on the current field.
- R4: Exactly one beat (`wrValid`=1 for one clock) is produced for each clock in which the qualifier is sampled active, and no beat is produced otherwise. A word sampled at rising edge k appears on the outputs after rising edge k+2, with `wrData` equal to that word.
- R5: `wrSol`=1 on the first beat of each line. `wrEol`=1 on the beat whose word is followed by an inactive qualifier sample. A one-word line has both flags set.
- R6: While `capEn`=0, no beats are produced, no field start happens and the status outputs hold their values.
- R7: `wrAddr` = base + line × `linePitch` + pixel, modulo 2^AW. Here base is `fieldBase` sampled at the field start, line counts active lines from 0 since that start, and pixel counts from 0 within the line.
- R8: A line period with no active qualifier produces no beats and does not advance the line index.
- R9: At each field start, `statPixels` takes the number of beats produced since the previous field start, and `statLines` takes the number of active lines completed in that interval.
- R10: After reset, `wrValid`, `statPixels` and `statLines` are 0.
- R11: `wrAlpha` carries the polarity-corrected alpha bit that was sampled with the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video clock from the decoder |
| rstN | input | 1 | Asynchronous reset, active low |
| capEn | input | 1 | High when this input timing mode is selected |
| polVref | input | 1 | 1 = vertical pulse is active-low |
| polField | input | 1 | 1 = field identifier is inverted |
| polVact | input | 1 | 1 = line-active qualifier is active-low |
| polAlpha | input | 1 | 1 = alpha key is inverted |
| vrefIn | input | 1 | Vertical pulse from the decoder |
| fieldIn | input | 1 | Field identification from the decoder |
| vactIn | input | 1 | Line-active qualifier from the decoder |
| alphaIn | input | 1 | Alpha-key bit from the decoder |
| dataIn | input | 16 | Pixel word from the decoder |
| fieldBase | input | 20 | Address of the first word of a field, sampled at field start |
| linePitch | input | 20 | Address step from one active line to the next |
| wrValid | output | 1 | Write beat valid |
| wrAddr | output | 20 | Linear write address |
| wrData | output | 16 | Captured pixel word |
| wrAlpha | output | 1 | Captured alpha bit |
| wrField | output | 1 | Field parity of this beat |
| wrSof | output | 1 | First beat of a field |
| wrSol | output | 1 | First beat of a line |
| wrEol | output | 1 | Last beat of a line |
| statPixels | output | 21 | Beats delivered in the previous field |
| statLines | output | 10 | Active lines delivered in the previous field |

## Verification
The bench sweeps all four polarity patterns. In each field it varies:

- the pulse length, from 2 to 9 lines;
- the line widths, including a one-word line;
- the gaps between lines, including a single inactive clock;
- blank line periods.

The single-clock gap distinguishes a correct end-of-line look-ahead from one that merges two lines. The blank periods distinguish skipping from counting, because the expected address and line count depend on that difference.

After each trailing edge, the bench toggles the field input and changes the base. This shows whether parity and base are latched at the edge or followed live. One field runs with `capEn` low, so the status outputs must carry the earlier field's counts through it.

// File: rtl/vcap_pkg.sv
package vcap_pkg;

  // Strobes from the control path to the datapath, valid for one cycle
  typedef struct packed {
    logic halt;        // mode deselected: drop line state
    logic fieldStart;  // trailing edge of the vertical pulse
    logic parity;      // parity in force for this cycle
    logic beat;        // emit a write beat this cycle
    logic sof;         // beat is first of the field
    logic sol;         // beat is first of the line
    logic eol;         // beat is last of the line
  } vcapStb_t;

endpackage

// File: rtl/vcapCtrl.sv
module vcapCtrl (
  input  logic               clk,
  input  logic               rstN,
  input  logic               capEn,
  input  logic               polVref,
  input  logic               polField,
  input  logic               polVact,
  input  logic               vrefIn,
  input  logic               fieldIn,
  input  logic               vactIn,
  output vcap_pkg::vcapStb_t stb
);

  // Two sampling stages after the polarity correction; the second stage
  // lets each word see whether the qualifier is still active behind it.
  logic vrefS1, vrefS2;
  logic fieldS1, fieldS2;
  logic vactS1, vactS2;
  logic parityQ;
  logic lineOpen;
  logic sofPending;

  logic vrefFall;
  logic startNow;
  logic beatNow;
  logic eolNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vrefS1  <= 1'b0;
      vrefS2  <= 1'b0;
      fieldS1 <= 1'b0;
      fieldS2 <= 1'b0;
      vactS1  <= 1'b0;
      vactS2  <= 1'b0;
    end else begin
      vrefS1  <= vrefIn ^ polVref;
      vrefS2  <= vrefS1;
      fieldS1 <= fieldIn ^ polField;
      fieldS2 <= fieldS1;
      vactS1  <= vactIn ^ polVact;
      vactS2  <= vactS1;
    end
  end

  always_comb begin
    vrefFall = vrefS2 & ~vrefS1;
    startNow = capEn & vrefFall;
    beatNow  = capEn & vactS2;
    eolNow   = beatNow & ~vactS1;

    stb.halt       = ~capEn;
    stb.fieldStart = startNow;
    stb.parity     = startNow ? fieldS2 : parityQ;
    stb.beat       = beatNow;
    stb.sof        = beatNow & (sofPending | startNow);
    stb.sol        = beatNow & ~lineOpen;
    stb.eol        = eolNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      parityQ    <= 1'b0;
      lineOpen   <= 1'b0;
      sofPending <= 1'b0;
    end else begin
      if (startNow) begin
        parityQ <= fieldS2;
      end

      if (startNow && !beatNow) begin
        sofPending <= 1'b1;
      end else if (beatNow) begin
        sofPending <= 1'b0;
      end

      if (!capEn) begin
        lineOpen <= 1'b0;
      end else if (beatNow) begin
        lineOpen <= ~eolNow;
      end
    end
  end

  // R2: one trailing edge, one field start
  p_start_once_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.fieldStart |=> !stb.fieldStart);

endmodule

// File: rtl/vcapData.sv
module vcapData #(
  parameter int unsigned DW       = 16,
  parameter int unsigned AW       = 20,
  parameter int unsigned PXW      = 11,
  parameter int unsigned LNW      = 10,
  parameter bit          ALPHA_EN = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               polAlpha,
  input  logic [DW-1:0]      dataIn,
  input  logic               alphaIn,
  input  logic [AW-1:0]      fieldBase,
  input  logic [AW-1:0]      linePitch,
  input  vcap_pkg::vcapStb_t stb,
  output logic               wrValid,
  output logic [AW-1:0]      wrAddr,
  output logic [DW-1:0]      wrData,
  output logic               wrAlpha,
  output logic               wrField,
  output logic               wrSof,
  output logic               wrSol,
  output logic               wrEol,
  output logic [PXW+LNW-1:0] statPixels,
  output logic [LNW-1:0]     statLines
);

  localparam int unsigned FCW = PXW + LNW;
  localparam logic [PXW-1:0] PIX_ONE  = PXW'(1);
  localparam logic [LNW-1:0] LINE_ONE = LNW'(1);
  localparam logic [FCW-1:0] CNT_ONE  = FCW'(1);

  logic [DW-1:0] dataS1, dataS2;
  logic          alphaS2;

  // Alpha pipeline only when the key input is present
  generate
    if (ALPHA_EN) begin : g_alpha
      logic alphaS1;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          alphaS1 <= 1'b0;
          alphaS2 <= 1'b0;
        end else begin
          alphaS1 <= alphaIn ^ polAlpha;
          alphaS2 <= alphaS1;
        end
      end
    end else begin : g_noAlpha
      assign alphaS2 = 1'b0;
    end
  endgenerate

  logic [PXW-1:0] pixIdx;
  logic [LNW-1:0] lineIdx;
  logic [AW-1:0]  lineAddr;
  logic [FCW-1:0] fieldPix;

  logic [PXW-1:0] curPix;
  logic [LNW-1:0] curLine;
  logic [AW-1:0]  curLineAddr;
  logic [FCW-1:0] curFieldPix;

  // A field start in the same cycle as a beat restarts the counters first
  always_comb begin
    curPix      = stb.fieldStart ? '0 : pixIdx;
    curLine     = stb.fieldStart ? '0 : lineIdx;
    curLineAddr = stb.fieldStart ? fieldBase : lineAddr;
    curFieldPix = stb.fieldStart ? '0 : fieldPix;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataS1 <= '0;
      dataS2 <= '0;
    end else begin
      dataS1 <= dataIn;
      dataS2 <= dataS1;
    end
  end

  // Output beat register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrValid <= 1'b0;
      wrAddr  <= '0;
      wrData  <= '0;
      wrAlpha <= 1'b0;
      wrField <= 1'b0;
      wrSof   <= 1'b0;
      wrSol   <= 1'b0;
      wrEol   <= 1'b0;
    end else begin
      wrValid <= stb.beat;
      if (stb.beat) begin
        wrAddr  <= curLineAddr + AW'(curPix);
        wrData  <= dataS2;
        wrAlpha <= alphaS2;
        wrField <= stb.parity;
        wrSof   <= stb.sof;
        wrSol   <= stb.sol;
        wrEol   <= stb.eol;
      end
    end
  end

  // Position counters and line address accumulator
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixIdx   <= '0;
      lineIdx  <= '0;
      lineAddr <= '0;
      fieldPix <= '0;
    end else if (stb.halt) begin
      pixIdx <= '0;
    end else if (stb.beat) begin
      fieldPix <= curFieldPix + CNT_ONE;
      if (stb.eol) begin
        pixIdx   <= '0;
        lineIdx  <= curLine + LINE_ONE;
        lineAddr <= curLineAddr + linePitch;
      end else begin
        pixIdx   <= curPix + PIX_ONE;
        lineIdx  <= curLine;
        lineAddr <= curLineAddr;
      end
    end else if (stb.fieldStart) begin
      pixIdx   <= '0;
      lineIdx  <= '0;
      lineAddr <= fieldBase;
      fieldPix <= '0;
    end
  end

  // Per-field status, loaded with the finished field's totals
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statPixels <= '0;
      statLines  <= '0;
    end else if (stb.fieldStart) begin
      statPixels <= fieldPix;
      statLines  <= lineIdx;
    end
  end

  // R5: an end-of-line beat is never immediately followed by another beat
  p_gap_after_eol_r5: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && wrEol |-> !stb.beat);

  // R7: a line-opening beat finds the pixel counter at zero
  p_sol_at_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.beat && stb.sol && !stb.fieldStart |-> pixIdx == '0);

  // R7: consecutive beats in one line step the address by one word
  p_addr_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && !wrEol && stb.beat && !stb.fieldStart
      |=> wrAddr == $past(wrAddr) + AW'(1));

  // R6: a deselected mode yields no beat
  p_halt_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.halt |=> !wrValid);

endmodule

// File: rtl/vcapFront.sv
module vcapFront #(
  parameter int unsigned DW       = 16,
  parameter int unsigned AW       = 20,
  parameter int unsigned PXW      = 11,
  parameter int unsigned LNW      = 10,
  parameter bit          ALPHA_EN = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               capEn,
  input  logic               polVref,
  input  logic               polField,
  input  logic               polVact,
  input  logic               polAlpha,
  input  logic               vrefIn,
  input  logic               fieldIn,
  input  logic               vactIn,
  input  logic               alphaIn,
  input  logic [DW-1:0]      dataIn,
  input  logic [AW-1:0]      fieldBase,
  input  logic [AW-1:0]      linePitch,
  output logic               wrValid,
  output logic [AW-1:0]      wrAddr,
  output logic [DW-1:0]      wrData,
  output logic               wrAlpha,
  output logic               wrField,
  output logic               wrSof,
  output logic               wrSol,
  output logic               wrEol,
  output logic [PXW+LNW-1:0] statPixels,
  output logic [LNW-1:0]     statLines
);

  vcap_pkg::vcapStb_t stb;

  vcapCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .capEn    (capEn),
    .polVref  (polVref),
    .polField (polField),
    .polVact  (polVact),
    .vrefIn   (vrefIn),
    .fieldIn  (fieldIn),
    .vactIn   (vactIn),
    .stb      (stb)
  );

  vcapData #(
    .DW       (DW),
    .AW       (AW),
    .PXW      (PXW),
    .LNW      (LNW),
    .ALPHA_EN (ALPHA_EN)
  ) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .polAlpha   (polAlpha),
    .dataIn     (dataIn),
    .alphaIn    (alphaIn),
    .fieldBase  (fieldBase),
    .linePitch  (linePitch),
    .stb        (stb),
    .wrValid    (wrValid),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .wrAlpha    (wrAlpha),
    .wrField    (wrField),
    .wrSof      (wrSof),
    .wrSol      (wrSol),
    .wrEol      (wrEol),
    .statPixels (statPixels),
    .statLines  (statLines)
  );

endmodule

// File: tb/sim_vcapFront.sv
module sim_vcapFront;

  localparam int CLK_PERIOD = 10;
  localparam int DW       = 16;
  localparam int AW       = 20;
  localparam int PXW      = 11;
  localparam int LNW      = 10;
  localparam int FCW      = PXW + LNW;
  localparam int LINE_LEN = 20;
  localparam int PITCH    = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic capEn;
  logic polVref, polField, polVact, polAlpha;
  logic vrefL, fieldL, vactL, alphaL;
  logic [DW-1:0] dataIn;
  logic [AW-1:0] fieldBase, linePitch;

  logic vrefIn, fieldIn, vactIn, alphaIn;
  logic wrValid, wrAlpha, wrField, wrSof, wrSol, wrEol;
  logic [AW-1:0]  wrAddr;
  logic [DW-1:0]  wrData;
  logic [FCW-1:0] statPixels;
  logic [LNW-1:0] statLines;

  // Logical levels are mapped to pin levels through the polarity bits
  assign vrefIn  = vrefL  ^ polVref;
  assign fieldIn = fieldL ^ polField;
  assign vactIn  = vactL  ^ polVact;
  assign alphaIn = alphaL ^ polAlpha;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vcapFront u0 (
    .clk(clk), .rstN(rstN), .capEn(capEn),
    .polVref(polVref), .polField(polField), .polVact(polVact), .polAlpha(polAlpha),
    .vrefIn(vrefIn), .fieldIn(fieldIn), .vactIn(vactIn), .alphaIn(alphaIn),
    .dataIn(dataIn), .fieldBase(fieldBase), .linePitch(linePitch),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData), .wrAlpha(wrAlpha),
    .wrField(wrField), .wrSof(wrSof), .wrSol(wrSol), .wrEol(wrEol),
    .statPixels(statPixels), .statLines(statLines)
  );

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic          alpha;
    logic          field;
    logic          sof;
    logic          sol;
    logic          eol;
  } beat_t;

  beat_t expQ[$];
  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;
  int accPix = 0, accLines = 0;
  int expStatPix = 0, expStatLines = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Beat monitor, sampled away from the rising edge
  beat_t e;
  always @(negedge clk) begin
    if (rstN && wrValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R4", "unexpected beat at address", longint'(wrAddr), 0);
      end else begin
        e = expQ.pop_front();
        check(wrAddr == e.addr, "R7", "write address", longint'(wrAddr), longint'(e.addr));
        check(wrData == e.data, "R4", "write data", longint'(wrData), longint'(e.data));
        check(wrAlpha == e.alpha, "R11", "alpha bit", longint'(wrAlpha), longint'(e.alpha));
        check(wrField == e.field, "R3", "field parity", longint'(wrField), longint'(e.field));
        check(wrSof == e.sof, "R2", "start of field", longint'(wrSof), longint'(e.sof));
        check({wrSol, wrEol} == {e.sol, e.eol}, "R5", "line flags",
              longint'({wrSol, wrEol}), longint'({e.sol, e.eol}));
      end
    end
  end

  function automatic int lineWidth(input int cfg, input int l);
    if ((l + cfg) % 4 == 2) return 0;   // blank line period (R8)
    if (l == 5) return 1;               // one-word line (R5)
    return 3 + (l * 7 + cfg * 5) % 14;
  endfunction

  task automatic runField(input int cfg, input bit par, input int pulseLines,
                          input int nLines, input logic [AW-1:0] base);
    int activeLine = 0;
    bit firstBeat  = 1'b1;
    beat_t b;
    // vertical pulse, R1/R2: pulse length varies between 2 and 9 lines
    @(negedge clk);
    fieldL = par;
    vrefL = 1'b1;
    fieldBase = base;
    repeat (pulseLines * LINE_LEN - 1) @(negedge clk);
    @(negedge clk);
    vrefL = 1'b0;
    @(negedge clk);
    @(negedge clk);
    fieldL = ~par;                      // R3: late change must be ignored
    @(negedge clk);
    @(negedge clk);
    fieldBase = ~base;                  // R7: base must already be latched
    if (capEn) begin
      expStatPix = accPix;
      expStatLines = accLines;
      accPix = 0;
      accLines = 0;
      check(int'(statPixels) == expStatPix, "R9", "field word count",
            longint'(statPixels), longint'(expStatPix));
      check(int'(statLines) == expStatLines, "R9", "field line count",
            longint'(statLines), longint'(expStatLines));
    end else begin
      check(int'(statPixels) == expStatPix, "R6", "held word count",
            longint'(statPixels), longint'(expStatPix));
      check(int'(statLines) == expStatLines, "R6", "held line count",
            longint'(statLines), longint'(expStatLines));
    end
    for (int l = 0; l < nLines; l++) begin
      int w = lineWidth(cfg, l);
      if (w == 0) begin
        repeat (LINE_LEN) @(negedge clk);
      end else begin
        for (int p = 0; p < w; p++) begin
          @(negedge clk);
          vactL  = 1'b1;
          dataIn = DW'(cfg * 4099 + l * 257 + p * 31 + 5);
          alphaL = ((p + l + cfg) % 2) == 0;
          if (capEn) begin
            b.addr  = base + AW'(activeLine * PITCH + p);
            b.data  = dataIn;
            b.alpha = alphaL;
            b.field = par;
            b.sof   = firstBeat;
            b.sol   = (p == 0);
            b.eol   = (p == w - 1);
            expQ.push_back(b);
            firstBeat = 1'b0;
            accPix++;
          end
        end
        @(negedge clk);
        vactL = 1'b0;
        repeat (l % 3) @(negedge clk);   // gap of 1 to 3 inactive clocks
        if (capEn) begin
          activeLine++;
          accLines++;
        end
      end
    end
    repeat (6) @(negedge clk);
  endtask

  initial begin
    capEn = 1'b1;
    polVref = 1'b0; polField = 1'b0; polVact = 1'b0; polAlpha = 1'b0;
    vrefL = 1'b0; fieldL = 1'b0; vactL = 1'b0; alphaL = 1'b0;
    dataIn = '0;
    fieldBase = '0;
    linePitch = AW'(PITCH);
    repeat (4) @(negedge clk);
    // R10: reset state
    check(wrValid == 1'b0, "R10", "valid in reset", longint'(wrValid), 0);
    check(statPixels == '0, "R10", "word count in reset", longint'(statPixels), 0);
    check(statLines == '0, "R10", "line count in reset", longint'(statLines), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(wrValid == 1'b0, "R10", "valid after reset", longint'(wrValid), 0);

    // R1: sweep every polarity combination
    for (int cfg = 0; cfg < 4; cfg++) begin
      int pulses [4] = '{2, 5, 9, 3};
      @(negedge clk);
      polVref  = cfg[0];
      polField = cfg[1];
      polVact  = cfg[0] ^ cfg[1];
      polAlpha = cfg[1];
      runField(cfg, cfg[0], pulses[cfg], 7, AW'(32'h1000 * (cfg + 1) + cfg * 3));
    end

    // R6: mode deselected for a whole field
    @(negedge clk);
    capEn = 1'b0;
    runField(4, 1'b1, 3, 6, AW'(32'h7000));
    @(negedge clk);
    capEn = 1'b1;
    runField(5, 1'b0, 4, 7, AW'(32'hFFFA0));   // address wraps modulo 2^AW
    runField(6, 1'b1, 2, 0, AW'(32'h2000));    // final count report

    check(expQ.size() == 0, "R4", "beats still expected", longint'(expQ.size()), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL R4 watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule